// File: doc/BRIEF.md
# Segment ID Scrambler

This block turns a request made of an address-space context number and the upper part of an effective address into a virtual segment identifier. The identifier is used to tag translations. It first forms an unscrambled segment key. For kernel requests it picks the context itself from the address region nibble. It then spreads the key over the identifier space by multiplying it by a fixed 24-bit prime. The product is reduced modulo 2^n-1 with two add-and-fold steps, so no divider is needed. The width n is 37 for 256 MB segments and 25 for 1 TB segments.

Requests enter through a valid/ready handshake. Each one passes through three register stages: multiply, first fold and final fold. One request can be accepted every cycle. When the consumer stalls, the whole pipeline holds. Addresses outside the mapped range return the reserved identifier 0. So do kernel requests whose region is below the first kernel region. Both cases still take a normal slot in the pipeline.

Top module: `vsid_scrambler`

## Requirements
- R1: For a 256 MB request the key is {context, ea[45:28]}, 37 bits wide, and the result is key*12538073 mod (2^37-1). For user requests the region nibble ea[63:60] has no effect.
- R2: For a 1 TB request the key is {context, ea[45:40]}, 25 bits wide, and the result is key*12538073 mod (2^25-1). Result bits 36:25 are zero.
- R3: A user request uses 1 TB segments only when req_big_seg=1 and ea[59:0] >= 2^40. Otherwise it uses 256 MB segments. The size used is reported on out_big_seg (1 = 1 TB).
- R4: A kernel request ignores req_ctx and uses context 0x7FFFC + (ea[63:60] - 0xC) for regions 0xC to 0xF. Its segment size is req_big_seg.
- R5: A kernel request with ea[63:60] < 0xC returns identifier 0.
- R6: A request with ea[59:0] >= 2^46 (parameter RANGE_BITS = 46) returns identifier 0.
- R7: The result is always below 2^n-1. A key of all ones therefore yields 0.
- R8: A request accepted at a clock edge shows up on out_valid after exactly three edges when out_ready stays high. Results leave in request order, at up to one per cycle, and req_ready is high whenever out_ready is high.
- R9: While out_valid=1 and out_ready=0, out_vsid and out_big_seg hold their values and req_ready is low.
- R10: During and right after reset, out_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_ctx | input | 19 | User context number |
| req_ea_hi | input | 36 | Effective address bits 63:28 |
| req_kernel | input | 1 | 1 = kernel request, 0 = user request |
| req_big_seg | input | 1 | Segment size: 1 = 1 TB, 0 = 256 MB |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vsid | output | 37 | Scrambled segment identifier |
| out_big_seg | output | 1 | Segment size used for this result |

## Verification
Directed requests cover four kinds of case:
- user addresses on each side of the 2^40 size boundary, with both size selects, which separates the size choice from the fold width;
- all four kernel regions, which expose an off-by-one in the derived context;
- regions and addresses just inside and just outside the valid range, which separate the two zero paths from a real result;
- keys of all ones, which catch a final fold that leaves 2^n-1 in place of 0.

A few hundred random requests with random consumer stalls are compared against a plain remainder computation. These catch fold carries that only some products produce and any reordering under backpressure. A filled, stalled pipeline shows whether results and the ready signal hold.

// File: rtl/vsid_pkg.sv
package vsid_pkg;

  localparam int CTX_W           = 19;
  localparam int MULT_W          = 24;
  localparam int REGION_W        = 4;
  localparam int ADDR_W          = 64;
  localparam int SMALL_SEG_SHIFT = 28;
  localparam int LARGE_SEG_SHIFT = 40;

  localparam logic [MULT_W-1:0]   SCRAMBLE_MULT       = 24'd12538073;
  localparam logic [REGION_W-1:0] FIRST_KERNEL_REGION = 4'hC;
  localparam logic [CTX_W-1:0]    LAST_USER_CTX       = CTX_W'((1 << CTX_W) - 5);

  // Kernel regions 0xC..0xF take the four contexts above the last user one.
  function automatic logic [CTX_W-1:0] kernel_context(input logic [REGION_W-1:0] region);
    logic [REGION_W-1:0] offs;
    offs = region - FIRST_KERNEL_REGION;
    return LAST_USER_CTX + CTX_W'(offs) + CTX_W'(1);
  endfunction

  // One add-and-fold step towards a residue modulo 2^n-1.
  function automatic logic [63:0] mersenne_fold(input logic [63:0] p, input int unsigned n);
    logic [63:0] mask;
    mask = (64'd1 << n) - 64'd1;
    return (p >> n) + (p & mask);
  endfunction

  // Final step: bring a value below 2^(n+1)-1 into the range 0 .. 2^n-2.
  function automatic logic [63:0] mersenne_finish(input logic [63:0] x, input int unsigned n);
    logic [63:0] mask;
    mask = (64'd1 << n) - 64'd1;
    return (x + ((x + 64'd1) >> n)) & mask;
  endfunction

endpackage

// File: rtl/vsid_front.sv
module vsid_front
  import vsid_pkg::*;
#(
  parameter int RANGE_BITS = 46
) (
  input  logic [CTX_W-1:0]                      req_ctx,
  input  logic [ADDR_W-1:SMALL_SEG_SHIFT]        req_ea_hi,
  input  logic                                  req_kernel,
  input  logic                                  req_big_seg,
  output logic [CTX_W+RANGE_BITS-SMALL_SEG_SHIFT-1:0] proto,
  output logic                                  big_seg,
  output logic                                  bad_addr
);

  localparam int ESID_S_W = RANGE_BITS - SMALL_SEG_SHIFT;
  localparam int ESID_L_W = RANGE_BITS - LARGE_SEG_SHIFT;
  localparam int VS_W     = CTX_W + ESID_S_W;
  localparam int VL_W     = CTX_W + ESID_L_W;
  localparam int TOP_LOW  = ADDR_W - REGION_W - 1;

  logic [REGION_W-1:0] region;
  logic                user_high;
  logic                kern_region_bad;
  logic                range_bad;
  logic [CTX_W-1:0]    ctx_sel;
  logic [ESID_S_W-1:0] esid_small;
  logic [ESID_L_W-1:0] esid_large;
  logic [VL_W-1:0]     proto_large;

  always_comb begin
    region          = req_ea_hi[ADDR_W-1:ADDR_W-REGION_W];
    user_high       = |req_ea_hi[TOP_LOW:LARGE_SEG_SHIFT];
    kern_region_bad = req_kernel && (region < FIRST_KERNEL_REGION);
    range_bad       = |req_ea_hi[TOP_LOW:RANGE_BITS];
    ctx_sel         = req_kernel ? kernel_context(region) : req_ctx;
    esid_small      = req_ea_hi[RANGE_BITS-1:SMALL_SEG_SHIFT];
    esid_large      = req_ea_hi[RANGE_BITS-1:LARGE_SEG_SHIFT];
    proto_large     = {ctx_sel, esid_large};
    big_seg         = req_kernel ? req_big_seg : (req_big_seg && user_high);
    bad_addr        = kern_region_bad || range_bad;
    proto           = big_seg ? VS_W'(proto_large) : {ctx_sel, esid_small};
  end

endmodule

// File: rtl/vsid_core.sv
module vsid_core
  import vsid_pkg::*;
#(
  parameter int VS_W = 37,
  parameter int VL_W = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VS_W-1:0] in_proto,
  input  logic            in_big,
  input  logic            in_bad,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VS_W-1:0] out_vsid,
  output logic            out_big
);

  localparam int PROD_W = VS_W + MULT_W;
  localparam int FOLD_W = VS_W + 1;

  logic              adv;
  logic              v1, v2, v3;
  logic              big1, big2, big3;
  logic              bad1, bad2;
  logic [PROD_W-1:0] prod1;
  logic [FOLD_W-1:0] fold2;
  logic [VS_W-1:0]   vsid3;

  logic [PROD_W-1:0] prod_c;
  logic [FOLD_W-1:0] fold_c;
  logic [VS_W-1:0]   vsid_c;
  int unsigned       n1, n2;

  assign adv      = !v3 || out_ready;
  assign in_ready = adv;

  always_comb begin
    n1     = big1 ? VL_W : VS_W;
    n2     = big2 ? VL_W : VS_W;
    prod_c = PROD_W'(in_proto) * PROD_W'(SCRAMBLE_MULT);
    fold_c = FOLD_W'(mersenne_fold(64'(prod1), n1));
    vsid_c = bad2 ? '0 : VS_W'(mersenne_finish(64'(fold2), n2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      prod1 <= prod_c;
      big1  <= in_big;
      bad1  <= in_bad;
      fold2 <= fold_c;
      big2  <= big1;
      bad2  <= bad1;
      vsid3 <= vsid_c;
      big3  <= big2;
    end
  end

  assign out_valid = v3;
  assign out_vsid  = vsid3;
  assign out_big   = big3;

endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
  import vsid_pkg::*;
#(
  parameter int RANGE_BITS = 46
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           req_valid,
  output logic                                           req_ready,
  input  logic [CTX_W-1:0]                               req_ctx,
  input  logic [ADDR_W-1:SMALL_SEG_SHIFT]                 req_ea_hi,
  input  logic                                           req_kernel,
  input  logic                                           req_big_seg,
  output logic                                           out_valid,
  input  logic                                           out_ready,
  output logic [CTX_W+RANGE_BITS-SMALL_SEG_SHIFT-1:0]    out_vsid,
  output logic                                           out_big_seg
);

  localparam int VS_W = CTX_W + RANGE_BITS - SMALL_SEG_SHIFT;
  localparam int VL_W = CTX_W + RANGE_BITS - LARGE_SEG_SHIFT;

  logic [VS_W-1:0] key_w;
  logic            key_big_w;
  logic            key_bad_w;

  vsid_front #(.RANGE_BITS(RANGE_BITS)) u_front (
    .req_ctx     (req_ctx),
    .req_ea_hi   (req_ea_hi),
    .req_kernel  (req_kernel),
    .req_big_seg (req_big_seg),
    .proto       (key_w),
    .big_seg     (key_big_w),
    .bad_addr    (key_bad_w)
  );

  vsid_core #(.VS_W(VS_W), .VL_W(VL_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_proto  (key_w),
    .in_big    (key_big_w),
    .in_bad    (key_bad_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vsid  (out_vsid),
    .out_big   (out_big_seg)
  );

endmodule

// File: rtl/vsid_scrambler_chk.sv
module vsid_scrambler_chk
  import vsid_pkg::*;
#(
  parameter int RANGE_BITS = 46
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic                                        req_valid,
  input logic                                        req_ready,
  input logic                                        out_valid,
  input logic                                        out_ready,
  input logic [CTX_W+RANGE_BITS-SMALL_SEG_SHIFT-1:0] out_vsid,
  input logic                                        out_big_seg
);

  localparam int VS_W = CTX_W + RANGE_BITS - SMALL_SEG_SHIFT;
  localparam int VL_W = CTX_W + RANGE_BITS - LARGE_SEG_SHIFT;

  logic       rst_seen_q;
  logic [2:0] inflight_q;
  logic       take_w;
  logic       give_w;

  assign take_w = req_valid && req_ready;
  assign give_w = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else inflight_q <= inflight_q + 3'(take_w) - 3'(give_w);
  end

  always_ff @(posedge clk) begin
    rst_seen_q <= !rst_n;
    if (rst_seen_q) begin
      AST_RESET_IDLE: assert (!out_valid && req_ready); // R10
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vsid) && $stable(out_big_seg)); // R9

  AST_BLOCKED_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready); // R9

  AST_READY_WHEN_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> req_ready); // R8

  AST_OUTPUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight_q != 3'd0); // R8

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= 3'd3); // R8

  AST_SMALL_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_big_seg |-> out_vsid != {VS_W{1'b1}}); // R7

  AST_LARGE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_big_seg |-> out_vsid[VS_W-1:VL_W] == '0 && out_vsid[VL_W-1:0] != {VL_W{1'b1}}); // R2

endmodule

bind vsid_scrambler vsid_scrambler_chk #(.RANGE_BITS(RANGE_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_vsid    (out_vsid),
  .out_big_seg (out_big_seg)
);

// File: tb/vsid_scrambler_test.sv
module vsid_scrambler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_ctx = '0;
  logic [63:28] req_ea_hi = '0;
  logic        req_kernel = 1'b0;
  logic        req_big_seg = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [36:0] out_vsid;
  logic        out_big_seg;

  always #2 clk = ~clk;

  vsid_scrambler uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_ea_hi(req_ea_hi), .req_kernel(req_kernel),
    .req_big_seg(req_big_seg), .out_valid(out_valid), .out_ready(out_ready),
    .out_vsid(out_vsid), .out_big_seg(out_big_seg)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int ready_mode = 0;
  string cur_tag = "";

  longint unsigned exp_q[$];
  bit              seg_q[$];
  string           tag_q[$];

  bit              held = 0;
  longint unsigned held_v = 0;

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_seg(input logic [63:0] ea, input bit kern, input bit big);
    longint unsigned low;
    low = ea & 64'h0FFF_FFFF_FFFF_FFFF;
    if (kern) return big;
    return big && (low >= (64'd1 << 40));
  endfunction

  function automatic longint unsigned ref_vsid(input logic [18:0] c, input logic [63:0] ea,
                                               input bit kern, input bit big);
    longint unsigned low, ctx, esid, key, modv;
    int region, n;
    bit seg;
    region = int'(ea[63:60]);
    low    = ea & 64'h0FFF_FFFF_FFFF_FFFF;
    seg    = ref_seg(ea, kern, big);
    ctx    = c;
    if (kern) begin
      if (region < 12) return 0;
      ctx = (64'd1 << 19) - 5 + (region - 12) + 1;
    end
    if (low >= (64'd1 << 46)) return 0;
    n    = seg ? 25 : 37;
    esid = seg ? (low >> 40) : (low >> 28);
    key  = ctx * (64'd1 << (n - 19)) + esid;
    modv = (64'd1 << n) - 1;
    return (key * 64'd12538073) % modv;
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // consumer readiness, changed just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (ready_mode == 1) out_ready = ($urandom_range(0, 3) != 0);
    else if (ready_mode == 2) out_ready = 1'b0;
    else out_ready = 1'b1;
  end

  // reference model and comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (held) check(out_valid && (out_vsid == held_v), "R9 output held under stall",
                      out_vsid, held_v);
      held   = out_valid && !out_ready;
      held_v = out_vsid;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R8 output without request", out_vsid, 0);
        else begin
          longint unsigned e;
          bit s;
          string t;
          e = exp_q.pop_front();
          s = seg_q.pop_front();
          t = tag_q.pop_front();
          check(out_vsid == e, t, out_vsid, e);
          check(out_big_seg == s, {t, " size"}, out_big_seg, s);
        end
      end
      if (req_valid && req_ready) begin
        logic [63:0] ea;
        ea = {req_ea_hi, 28'h0};
        exp_q.push_back(ref_vsid(req_ctx, ea, req_kernel, req_big_seg));
        seg_q.push_back(ref_seg(ea, req_kernel, req_big_seg));
        tag_q.push_back(cur_tag);
      end
    end
  end

  // called just after a rising edge; returns just after the accepting edge
  task automatic send(input logic [18:0] c, input logic [63:0] ea, input bit kern,
                      input bit big, input string tag);
    bit ok;
    req_ctx     = c;
    req_ea_hi   = ea[63:28];
    req_kernel  = kern;
    req_big_seg = big;
    cur_tag     = tag;
    req_valid   = 1'b1;
    do begin
      @(negedge clk);
      ok = req_ready;
      @(posedge clk);
      #1;
    end while (!ok);
  endtask

  task automatic idle;
    req_valid = 1'b0;
  endtask

  task automatic drain;
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R10 out_valid in reset", out_valid, 0);
    check(req_ready, "R10 req_ready in reset", req_ready, 1);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R10 out_valid after reset", out_valid, 0);
    @(posedge clk);
    #1;

    // directed cases, out_ready held high
    send(19'h12345, 64'h0000_0000_ABCD_1234, 0, 1, "R3 low user address forced 256M");
    send(19'h0ABCD, 64'h7000_0012_3000_0000, 0, 0, "R1 user region nibble ignored");
    send(19'h0ABCD, 64'h0000_0012_3000_0000, 0, 0, "R1 user 256M");
    send(19'h00001, 64'h0000_2A00_0000_0000, 0, 1, "R2 user 1T");
    send(19'h7FFF0, 64'h0000_00FF_FFFF_FFFF, 0, 1, "R3 just below 2^40");
    send(19'h7FFF0, 64'h0000_0100_0000_0000, 0, 1, "R3 at 2^40 large select");
    send(19'h7FFF0, 64'h0000_0100_0000_0000, 0, 0, "R3 at 2^40 small select");
    for (int r = 12; r < 16; r++) begin
      logic [63:0] ea;
      ea = {4'(r), 60'h0000_1234_5678_9AB};
      send(19'h55555, ea, 1, 0, "R4 kernel region 256M");
      send(19'h2AAAA, ea, 1, 1, "R4 kernel region 1T");
    end
    send(19'h00003, 64'hB000_0000_1000_0000, 1, 0, "R5 kernel region 0xB");
    send(19'h00003, 64'h0000_0000_1000_0000, 1, 1, "R5 kernel region 0x0");
    send(19'h00005, 64'h0000_4000_0000_0000, 0, 0, "R6 at range limit");
    send(19'h00005, 64'h0000_3FFF_FFFF_FFFF, 0, 0, "R6 just below range limit");
    send(19'h00005, 64'hC000_8000_0000_0000, 1, 1, "R6 kernel out of range");
    send(19'h00000, 64'hF000_3FFF_F000_0000, 1, 0, "R7 all-ones key 256M");
    send(19'h00000, 64'hF000_3F00_0000_0000, 1, 1, "R7 all-ones key 1T");
    idle();
    drain();

    // latency of a single request
    begin
      int k;
      send(19'h00777, 64'h0000_0001_2000_0000, 0, 0, "R8 latency request");
      idle();
      k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (!out_valid && k < 10);
      check(k == 3, "R8 three-edge latency", k, 3);
      @(posedge clk);
      #1;
    end
    drain();

    // stall with a full pipeline
    ready_mode = 2;
    @(posedge clk);
    #1;
    send(19'h01010, 64'h0000_0000_4000_0000, 0, 0, "R9 stalled request a");
    send(19'h02020, 64'h0000_3100_0000_0000, 0, 1, "R9 stalled request b");
    send(19'h03030, 64'hD000_0000_7000_0000, 1, 0, "R9 stalled request c");
    idle();
    @(negedge clk);
    check(!req_ready, "R9 req_ready low when full and stalled", req_ready, 0);
    check(out_valid, "R9 result waiting", out_valid, 1);
    repeat (4) @(negedge clk);
    @(posedge clk);
    #1;
    ready_mode = 0;
    drain();

    // random traffic with random stalls
    ready_mode = 1;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ea;
      bit kern, big;
      logic [18:0] c;
      kern = ($urandom_range(0, 3) == 0);
      big  = $urandom_range(0, 1);
      c    = 19'($urandom);
      ea   = {$urandom, $urandom};
      if ($urandom_range(0, 7) != 0) ea[59:46] = '0;
      if ($urandom_range(0, 3) == 0) ea[45:40] = '0;
      if (kern && $urandom_range(0, 5) != 0) ea[63:62] = 2'b11;
      send(c, ea, kern, big, kern ? "R4 random kernel" : (big ? "R2 random user" : "R1 random user"));
      if ($urandom_range(0, 4) == 0) begin
        idle();
        @(posedge clk);
        #1;
      end
    end
    idle();
    ready_mode = 0;
    drain();

    check(exp_q.size() == 0, "R8 every request produced one result", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule